// File: doc/BRIEF.md
# Multi-Target Indirect Jump Selector

This block serves a front end that wants to predicate over more than one target of a hard-to-predict indirect jump. For each jump it tracks three candidate targets, and each target has a small frequency counter. On a lookup it reports the two most frequent targets, which serve as the two predication paths. When one target clearly outweighs the others, it instead reports that single target as an override, and the front end then skips predication.

The counters sit in a 256-entry selection table. The table index is the XOR of two byte-wide fields of the jump address. The target addresses themselves sit in a separate 1024-entry target store. Each of the three slots reaches that store through its own hash, and the three hashes differ by a fixed XOR key. A resolve port reports the real target of an executed jump. On a resolve, the block either counts up the matching slot or installs the target in place of the weakest slot. Because of this, the last target seen is always one of the three candidates.

Top module: `jump_target_selector`

## Requirements
- R1: While reset is high and in the cycle after it, out_valid and out_override are low, and every selection entry starts with all three counters at zero.
- R2: A lookup presented with lk_en high in one cycle is reported on the outputs in the next cycle. A cycle with lk_en low yields out_valid low in the following cycle.
- R3: A lookup of an entry whose three counters are all zero reports a miss: out_valid low and out_override low.
- R4: A resolved target that matches no slot with a non-zero counter is written into the slot with the lowest counter (ties go to slot 0, then 1, then 2), and that counter is set to 1.
- R5: A resolved target that matches a slot with a non-zero counter increments that slot's 4-bit counter. The target store is left untouched.
- R6: When an increment brings a counter to 15, all three counters of the entry are halved (rounded down) in the same update, so 15 is never stored.
- R7: Without override, out_tgt0 is the target of the highest counter and out_tgt1 is the target of the second-highest. Equal counters rank the lower slot index first.
- R8: Override is signalled when the top counter is at least 8 and at least twice the sum of the other two. out_override is then high, and out_tgt0 and out_tgt1 both carry the dominant target.
- R9: When only one slot has a non-zero counter and there is no override, out_tgt1 repeats out_tgt0.
- R10: A lookup and a resolve to the same entry in the same cycle: the lookup reports the state before the resolve, and the next lookup sees the update.
- R11: Jumps that map to different selection entries keep independent counters and targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | 32 | Address of the jump being looked up |
| rs_en | input | 1 | Resolve request |
| rs_pc | input | 32 | Address of the resolved jump |
| rs_tgt | input | TGT_W | Actual target of the resolved jump |
| out_valid | output | 1 | Registered lookup hit |
| out_override | output | 1 | Single dominant target, no predication |
| out_tgt0 | output | TGT_W | First predication path or override target |
| out_tgt1 | output | TGT_W | Second predication path |

## Verification
One jump is fed three distinct targets and then a fourth. This shows the placement in empty slots, the ranking of equal counters by slot index, and the choice of the victim among tied low counters. A second jump is hammered with a single target and then diluted with a competitor. This sweeps the override rule across both of its limits: the floor of 8 and the twice-the-rest ratio. A third jump drives a counter to 15 so the halving can be seen: the former leader falls below a rival it would otherwise still beat. A final pattern issues a lookup and a resolve to the same entry in one cycle, followed by idle cycles. This separates the reported state before and after the update, and shows the one-cycle output timing.

// File: rtl/jts_pkg.sv
package jts_pkg;
    localparam int PC_W    = 32;
    localparam int NSLOT   = 3;
    localparam int CNT_W   = 4;
    localparam int SEL_AW  = 8;
    localparam int STO_AW  = 10;
    localparam int SEL_N   = 1 << SEL_AW;
    localparam int STO_N   = 1 << STO_AW;
    localparam int DOM_MIN = 8;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef cnt_t [NSLOT-1:0]  cnt_vec_t;
    typedef logic [1:0]        slot_t;
    typedef logic [SEL_AW-1:0] sel_idx_t;
    typedef logic [STO_AW-1:0] sto_idx_t;

    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        logic  valid;
        logic  ovr;
        slot_t first;
        slot_t second;
    } pick_t;

    function automatic sel_idx_t sel_hash(input pc_t pc);
        return pc[2 +: SEL_AW] ^ pc[2 + SEL_AW +: SEL_AW];
    endfunction

    function automatic sto_idx_t slot_key(input int k);
        case (k)
            1:       return sto_idx_t'(10'h155);
            2:       return sto_idx_t'(10'h2AA);
            default: return '0;
        endcase
    endfunction

    function automatic sto_idx_t sto_hash(input pc_t pc, input int k);
        return pc[2 +: STO_AW] ^ pc[2 + STO_AW +: STO_AW] ^ slot_key(k);
    endfunction
endpackage

// File: rtl/jts_cnt_table.sv
module jts_cnt_table
    import jts_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  sel_idx_t lk_idx,
    output cnt_vec_t lk_cnt,
    input  sel_idx_t rs_idx,
    output cnt_vec_t rs_cnt,
    input  logic     wr_en,
    input  sel_idx_t wr_idx,
    input  cnt_vec_t wr_cnt
);
    cnt_vec_t mem [SEL_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SEL_N; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_cnt;
        end
    end

    assign lk_cnt = mem[lk_idx];
    assign rs_cnt = mem[rs_idx];

    for (genvar k = 0; k < NSLOT; k++) begin : g_sat
        // R6
        no_sat_store_chk: assert property (@(posedge clk) disable iff (rst)
            wr_en |-> wr_cnt[k] != CNT_MAX);
    end
endmodule

// File: rtl/jts_tgt_store.sv
module jts_tgt_store
    import jts_pkg::*;
#(
    parameter int TGT_W = 32
) (
    input  logic                        clk,
    input  logic [NSLOT-1:0][STO_AW-1:0] lk_addr,
    output logic [NSLOT-1:0][TGT_W-1:0]  lk_tgt,
    input  logic [NSLOT-1:0][STO_AW-1:0] rs_addr,
    output logic [NSLOT-1:0][TGT_W-1:0]  rs_tgt,
    input  logic                        wr_en,
    input  sto_idx_t                    wr_addr,
    input  logic [TGT_W-1:0]            wr_tgt
);
    logic [TGT_W-1:0] mem [STO_N];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_tgt;
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_rd
        assign lk_tgt[k] = mem[lk_addr[k]];
        assign rs_tgt[k] = mem[rs_addr[k]];
    end
endmodule

// File: rtl/jts_rank.sv
module jts_rank
    import jts_pkg::*;
(
    input  cnt_vec_t cnt,
    output pick_t    pick
);
    slot_t first, second;
    int    top_c, rest_c;

    always_comb begin
        first = '0;
        for (int k = 1; k < NSLOT; k++)
            if (cnt[k] > cnt[first]) first = slot_t'(k);

        second = (first == 2'd0) ? 2'd1 : 2'd0;
        for (int k = 0; k < NSLOT; k++)
            if (slot_t'(k) != first && cnt[k] > cnt[second]) second = slot_t'(k);
        if (cnt[second] == '0) second = first;

        top_c  = int'(cnt[first]);
        rest_c = 0;
        for (int k = 0; k < NSLOT; k++) rest_c += int'(cnt[k]);
        rest_c -= top_c;

        pick.valid  = (cnt != '0);
        pick.ovr    = (top_c >= DOM_MIN) && (top_c >= 2 * rest_c);
        pick.first  = first;
        pick.second = second;
    end
endmodule

// File: rtl/jump_target_selector.sv
module jump_target_selector
    import jts_pkg::*;
#(
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_en,
    input  logic [31:0]      lk_pc,
    input  logic             rs_en,
    input  logic [31:0]      rs_pc,
    input  logic [TGT_W-1:0] rs_tgt,
    output logic             out_valid,
    output logic             out_override,
    output logic [TGT_W-1:0] out_tgt0,
    output logic [TGT_W-1:0] out_tgt1
);
    logic [NSLOT-1:0][STO_AW-1:0] lk_addr, rs_addr;
    logic [NSLOT-1:0][TGT_W-1:0]  lk_tgt, rs_rd_tgt;
    cnt_vec_t lk_cnt, rs_cnt, nx_cnt;
    pick_t    pick;
    logic [NSLOT-1:0] hit;
    slot_t    match, victim;
    logic     sto_we;
    cnt_t     inc;

    for (genvar k = 0; k < NSLOT; k++) begin : g_addr
        assign lk_addr[k] = sto_hash(lk_pc, k);
        assign rs_addr[k] = sto_hash(rs_pc, k);
        assign hit[k]     = (rs_cnt[k] != '0) && (rs_rd_tgt[k] == rs_tgt);
    end

    jts_cnt_table u_cnt (
        .clk    (clk),
        .rst    (rst),
        .lk_idx (sel_hash(lk_pc)),
        .lk_cnt (lk_cnt),
        .rs_idx (sel_hash(rs_pc)),
        .rs_cnt (rs_cnt),
        .wr_en  (rs_en),
        .wr_idx (sel_hash(rs_pc)),
        .wr_cnt (nx_cnt)
    );

    jts_tgt_store #(.TGT_W(TGT_W)) u_sto (
        .clk     (clk),
        .lk_addr (lk_addr),
        .lk_tgt  (lk_tgt),
        .rs_addr (rs_addr),
        .rs_tgt  (rs_rd_tgt),
        .wr_en   (sto_we),
        .wr_addr (rs_addr[victim]),
        .wr_tgt  (rs_tgt)
    );

    jts_rank u_rank (
        .cnt  (lk_cnt),
        .pick (pick)
    );

    // resolve: count up a matching slot or replace the weakest one
    always_comb begin
        match = '0;
        for (int k = NSLOT - 1; k >= 0; k--)
            if (hit[k]) match = slot_t'(k);
        victim = '0;
        for (int k = 1; k < NSLOT; k++)
            if (rs_cnt[k] < rs_cnt[victim]) victim = slot_t'(k);

        nx_cnt = rs_cnt;
        inc    = rs_cnt[match] + cnt_t'(1);
        sto_we = 1'b0;
        if (|hit) begin
            nx_cnt[match] = inc;
            if (inc == CNT_MAX)
                for (int k = 0; k < NSLOT; k++) nx_cnt[k] = nx_cnt[k] >> 1;
        end else begin
            nx_cnt[victim] = cnt_t'(1);
            sto_we         = rs_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_override <= 1'b0;
            out_tgt0     <= '0;
            out_tgt1     <= '0;
        end else begin
            out_valid    <= lk_en & pick.valid;
            out_override <= lk_en & pick.valid & pick.ovr;
            out_tgt0     <= lk_tgt[pick.first];
            out_tgt1     <= pick.ovr ? lk_tgt[pick.first] : lk_tgt[pick.second];
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !out_valid && !out_override);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_en |=> !out_valid);

    // R8
    ovr_paths_chk: assert property (@(posedge clk) disable iff (rst)
        out_override |-> out_valid && out_tgt0 == out_tgt1);

    // R7
    rank_order_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> lk_cnt[pick.first] >= lk_cnt[pick.second]);
endmodule

// File: tb/jump_target_selector_tb.sv
`timescale 1ns/1ps
module jump_target_selector_tb;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_en = 1'b0;
    logic [31:0]   lk_pc = '0;
    logic          rs_en = 1'b0;
    logic [31:0]   rs_pc = '0;
    logic [TW-1:0] rs_tgt = '0;
    logic          out_valid, out_override;
    logic [TW-1:0] out_tgt0, out_tgt1;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    jump_target_selector #(.TGT_W(TW)) u_dut (
        .clk(clk), .rst(rst),
        .lk_en(lk_en), .lk_pc(lk_pc),
        .rs_en(rs_en), .rs_pc(rs_pc), .rs_tgt(rs_tgt),
        .out_valid(out_valid), .out_override(out_override),
        .out_tgt0(out_tgt0), .out_tgt1(out_tgt1)
    );

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic resolve(input logic [31:0] pc, input logic [TW-1:0] t);
        @(negedge clk);
        rs_en = 1'b1; rs_pc = pc; rs_tgt = t;
        @(negedge clk);
        rs_en = 1'b0;
    endtask

    task automatic look(input string tag, input logic [31:0] pc, input logic ev, input logic eo,
                        input logic [TW-1:0] e0, input logic [TW-1:0] e1);
        @(negedge clk);
        lk_en = 1'b1; lk_pc = pc;
        @(negedge clk);
        lk_en = 1'b0;
        check({tag, " valid"}, TW'(out_valid), TW'(ev));
        check({tag, " override"}, TW'(out_override), TW'(eo));
        if (ev) begin
            check({tag, " tgt0"}, out_tgt0, e0);
            check({tag, " tgt1"}, out_tgt1, e1);
        end
    endtask

    task automatic t_reset();
        check("R1 valid in reset", TW'(out_valid), '0);
        check("R1 override in reset", TW'(out_override), '0);
        look("R1_R3 empty entry", 32'h1000, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_fill_order();
        resolve(32'h1000, 32'hA0);
        look("R4_R9 first install", 32'h1000, 1'b1, 1'b0, 32'hA0, 32'hA0);
        resolve(32'h1000, 32'hB0);
        look("R4_R7 tie ranks slot0", 32'h1000, 1'b1, 1'b0, 32'hA0, 32'hB0);
        resolve(32'h1000, 32'hC0);
        look("R4 three slots", 32'h1000, 1'b1, 1'b0, 32'hA0, 32'hB0);
        resolve(32'h1000, 32'hC0);
        look("R5_R7 match counts up", 32'h1000, 1'b1, 1'b0, 32'hC0, 32'hA0);
        resolve(32'h1000, 32'hD0);
        look("R4 victim lowest tie slot0", 32'h1000, 1'b1, 1'b0, 32'hC0, 32'hD0);
        look("R11 other entry empty", 32'h2000, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic t_override();
        for (int i = 0; i < 7; i++) resolve(32'h2000, 32'h111);
        look("R8_R9 seven below floor", 32'h2000, 1'b1, 1'b0, 32'h111, 32'h111);
        resolve(32'h2000, 32'h111);
        look("R8 floor reached", 32'h2000, 1'b1, 1'b1, 32'h111, 32'h111);
        for (int i = 0; i < 4; i++) resolve(32'h2000, 32'h222);
        look("R8 ratio exactly two", 32'h2000, 1'b1, 1'b1, 32'h111, 32'h111);
        resolve(32'h2000, 32'h222);
        look("R8 ratio broken", 32'h2000, 1'b1, 1'b0, 32'h111, 32'h222);
        look("R11 first entry intact", 32'h1000, 1'b1, 1'b0, 32'hC0, 32'hD0);
    endtask

    task automatic t_halving();
        for (int i = 0; i < 14; i++) resolve(32'h3000, 32'h333);
        for (int i = 0; i < 2; i++) resolve(32'h3000, 32'h444);
        look("R8 fourteen vs two", 32'h3000, 1'b1, 1'b1, 32'h333, 32'h333);
        resolve(32'h3000, 32'h333);
        look("R6 halved below floor", 32'h3000, 1'b1, 1'b0, 32'h333, 32'h444);
        for (int i = 0; i < 7; i++) resolve(32'h3000, 32'h444);
        look("R6 rival overtakes halved", 32'h3000, 1'b1, 1'b0, 32'h444, 32'h333);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_en = 1'b1; lk_pc = 32'h4000;
        rs_en = 1'b1; rs_pc = 32'h4000; rs_tgt = 32'h555;
        @(negedge clk);
        lk_en = 1'b0; rs_en = 1'b0;
        check("R10 old state seen", TW'(out_valid), '0);
        look("R10 update seen next", 32'h4000, 1'b1, 1'b0, 32'h555, 32'h555);
        @(negedge clk);
        check("R2 idle gives no valid", TW'(out_valid), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", TW'(out_valid), '0);
        t_reset();
        t_fill_order();
        t_override();
        t_halving();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule